// File: doc/BRIEF.md
# ISA Bus Cycle Wait-State Sequencer

This block times one expansion-bus command cycle at a time, counting in bus-clock (BCLK) periods. It runs on BCLK itself. A bus-translation controller pulses `start` together with the cycle attributes: memory or I/O, and 8-bit or 16-bit device. The block then holds the command strobe for the length of the cycle and pulses `done` when the cycle is over. It also reports how many BCLKs the finished cycle took.

The default length depends on the device width. A device can ask for a shorter cycle by pulling the active-low zero-wait-state line low. A not-ready device stretches the cycle by holding channel-ready low, and channel-ready low always wins over a zero-wait-state request seen in the same clock. When the cycle targets the controller's own registers, the block drives the zero-wait-state line itself and treats its own request as seen. The BCLK counter saturates at its all-ones value.

The state machine has three states. ST_IDLE moves to ST_LEAD on `start`. ST_LEAD is BCLK 1, where nothing is sampled, and it always moves to ST_RUN. ST_RUN covers BCLK 2 and later. It samples `nows_n` and `chrdy` at every rising edge and moves back to ST_IDLE on the edge that ends the cycle. It stays in ST_RUN otherwise.

Top module: `isa_ws_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle: `cmd_act`, `done` and `nows_oe` are 0, `nows_out_n` is 1 and `cyc_len` is 0.
- R2: A 16-bit cycle of either type, with no zero-wait-state request and `chrdy` high, lasts 3 BCLKs.
- R3: A 16-bit memory cycle that sees `nows_n` low and `chrdy` high at the end of BCLK 2 lasts 2 BCLKs. No finished cycle is shorter than 2 BCLKs.
- R4: A 16-bit I/O cycle lasts 3 BCLKs whatever `nows_n` does.
- R5: With `chrdy` high, an 8-bit cycle lasts 6 BCLKs by default. A request seen at the end of BCLK 3 gives 4 BCLKs. A request seen at the end of BCLK 4 gives 5 BCLKs. A request seen in BCLK 2 or in BCLK 5 or later has no effect.
- R6: A cycle never ends on an edge where `chrdy` is low. A zero-wait-state request seen on such an edge is ignored, and the cycle ends on the first edge, at or after its due length, where `chrdy` is high.
- R7: `done` is high for exactly one clock, in the clock after the last BCLK, and `cmd_act` is low in that same clock. `cyc_len` then holds the finished cycle's BCLK count, unchanged until the next cycle ends.
- R8: For a register access (`reg_hit` high at start), `nows_oe` is high and `nows_out_n` is low from BCLK 2 through the last BCLK. At all other times `nows_oe` is low. The access is timed as though `nows_n` were low in every BCLK.
- R9: The attributes are latched when `start` is accepted in idle. `start` and attribute changes during a cycle have no effect on that cycle.
- R10: `cmd_act` is high from the clock after the accepted `start` through the last BCLK, for exactly `cyc_len` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | BCLK, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Cycle start strobe, accepted only in idle |
| io_cycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| wide16 | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| reg_hit | input | 1 | 1 = cycle targets the controller's own registers |
| nows_n | input | 1 | Zero-wait-state request from the bus, active low |
| chrdy | input | 1 | Channel ready, low inserts wait states |
| cmd_act | output | 1 | Command strobe, high during the cycle |
| done | output | 1 | One-clock cycle-finished pulse |
| nows_oe | output | 1 | Drive enable for the zero-wait-state line; low means high impedance |
| nows_out_n | output | 1 | Value driven on the zero-wait-state line when enabled |
| cyc_len | output | CNT_W | BCLK count of the last finished cycle |

## Verification
The assertions assume that `chrdy` does not stay low for so long that the BCLK counter saturates, and that `nows_n` and `chrdy` are synchronous to BCLK. Under those assumptions every cycle ends and lasts at least two clocks. The stimulus drives all inputs at the falling edge. It limits random not-ready stretches to a few BCLKs within the first dozen, so every cycle finishes well below the counter limit. Random and directed cycles both set the request and ready lines per BCLK from bit patterns, so the request can land in BCLK 2, 3, 4 or later, with and without `chrdy` low at the same time.

// File: rtl/isa_ws_pkg.sv
package isa_ws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_RUN
    } seq_state_t;

    localparam int LEN_W16_DEFAULT = 3;
    localparam int LEN_W16_MEM_FAST = 2;
    localparam int LEN_W8_DEFAULT = 6;
    localparam int LEN_W8_EARLY = 4;
    localparam int LEN_W8_LATE = 5;

    localparam int IDX_W8_EARLY = 3;
    localparam int IDX_W8_LATE = 4;

endpackage

// File: rtl/isa_ws_target.sv
module isa_ws_target
    import isa_ws_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             load_wide,
    input  logic             cur_wide,
    input  logic             shorten,
    input  logic [CNT_W-1:0] bclk_idx,
    output logic [CNT_W-1:0] due_len
);

    localparam logic [CNT_W-1:0] DEF16 = CNT_W'(LEN_W16_DEFAULT);
    localparam logic [CNT_W-1:0] DEF8 = CNT_W'(LEN_W8_DEFAULT);
    localparam logic [CNT_W-1:0] EARLY8 = CNT_W'(LEN_W8_EARLY);
    localparam logic [CNT_W-1:0] LATE8 = CNT_W'(LEN_W8_LATE);
    localparam logic [CNT_W-1:0] IDX_E = CNT_W'(IDX_W8_EARLY);
    localparam logic [CNT_W-1:0] IDX_L = CNT_W'(IDX_W8_LATE);

    logic [CNT_W-1:0] due_q;
    logic             untouched;

    assign untouched = (due_q == DEF8);

    always_ff @(posedge clk) begin
        if (rst) begin
            due_q <= DEF16;
        end else if (load) begin
            due_q <= load_wide ? DEF16 : DEF8;
        end else if (!cur_wide && shorten && untouched) begin
            if (bclk_idx == IDX_E) begin
                due_q <= EARLY8;
            end else if (bclk_idx == IDX_L) begin
                due_q <= LATE8;
            end
        end
    end

    assign due_len = due_q;

endmodule

// File: rtl/isa_ws_counter.sv
module isa_ws_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    input  logic             capture,
    output logic [CNT_W-1:0] bclk_idx,
    output logic [CNT_W-1:0] held_len
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= CNT_ONE;
        end else if (adv && (idx_q != CNT_MAX)) begin
            idx_q <= idx_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (capture) begin
            len_q <= idx_q;
        end
    end

    assign bclk_idx = idx_q;
    assign held_len = len_q;

endmodule

// File: rtl/isa_ws_seq.sv
module isa_ws_seq
    import isa_ws_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             io_cycle,
    input  logic             wide16,
    input  logic             reg_hit,
    input  logic             nows_n,
    input  logic             chrdy,
    output logic             cmd_act,
    output logic             done,
    output logic             nows_oe,
    output logic             nows_out_n,
    output logic [CNT_W-1:0] cyc_len
);

    localparam logic [CNT_W-1:0] FAST_IDX = CNT_W'(LEN_W16_MEM_FAST);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             io_q;
    logic             wide_q;
    logic             reg_q;
    logic             done_q;
    logic             accept;
    logic             in_run;
    logic             req_seen;
    logic             req_valid;
    logic             fast16;
    logic             finish;
    logic [CNT_W-1:0] bclk_idx;
    logic [CNT_W-1:0] due_len;

    assign accept    = (state_q == ST_IDLE) && start;
    assign in_run    = (state_q == ST_RUN);
    assign req_seen  = !nows_n || reg_q;
    assign req_valid = req_seen && chrdy;
    assign fast16    = wide_q && !io_q && (bclk_idx == FAST_IDX) && req_valid;
    assign finish    = in_run && chrdy && ((bclk_idx >= due_len) || fast16);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LEAD;
            ST_LEAD: state_d = ST_RUN;
            ST_RUN:  if (finish) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_q   <= 1'b0;
            wide_q <= 1'b1;
            reg_q  <= 1'b0;
        end else if (accept) begin
            io_q   <= io_cycle;
            wide_q <= wide16;
            reg_q  <= reg_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
        end
    end

    always_comb begin
        cmd_act    = (state_q != ST_IDLE);
        done       = done_q;
        nows_oe    = in_run && reg_q;
        nows_out_n = !(in_run && reg_q);
    end

    isa_ws_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .adv      ((state_q != ST_IDLE) && !finish),
        .capture  (finish),
        .bclk_idx (bclk_idx),
        .held_len (cyc_len)
    );

    isa_ws_target #(.CNT_W(CNT_W)) u_tgt (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_wide (wide16),
        .cur_wide  (wide_q),
        .shorten   (in_run && req_valid),
        .bclk_idx  (bclk_idx),
        .due_len   (due_len)
    );

endmodule

// File: rtl/isa_ws_seq_chk.sv
module isa_ws_seq_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             chrdy,
    input logic             cmd_act,
    input logic             done,
    input logic             nows_oe,
    input logic             nows_out_n,
    input logic [CNT_W-1:0] cyc_len
);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cmd_act && $past(cmd_act)));

    p_len_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cyc_len));

    p_min_len_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (cyc_len >= CNT_W'(2)));

    p_not_ready_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_act && !chrdy) |=> cmd_act);

    p_drive_in_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        nows_oe |-> (cmd_act && !nows_out_n));

endmodule

bind isa_ws_seq isa_ws_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chrdy      (chrdy),
    .cmd_act    (cmd_act),
    .done       (done),
    .nows_oe    (nows_oe),
    .nows_out_n (nows_out_n),
    .cyc_len    (cyc_len)
);

// File: tb/isa_ws_seq_test.sv
module isa_ws_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             io_cycle = 1'b0;
    logic             wide16 = 1'b1;
    logic             reg_hit = 1'b0;
    logic             nows_n = 1'b1;
    logic             chrdy = 1'b1;
    logic             cmd_act;
    logic             done;
    logic             nows_oe;
    logic             nows_out_n;
    logic [CNT_W-1:0] cyc_len;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    isa_ws_seq #(.CNT_W(CNT_W)) uut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .io_cycle   (io_cycle),
        .wide16     (wide16),
        .reg_hit    (reg_hit),
        .nows_n     (nows_n),
        .chrdy      (chrdy),
        .cmd_act    (cmd_act),
        .done       (done),
        .nows_oe    (nows_oe),
        .nows_out_n (nows_out_n),
        .cyc_len    (cyc_len)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected length from the requirements: zp bit k = request in BCLK k,
    // rp bit k = channel-ready low in BCLK k.
    function automatic int exp_len(input bit w16, input bit io, input bit rg,
                                   input logic [31:0] zp, input logic [31:0] rp);
        int due;
        due = w16 ? 3 : 6;
        for (int k = 2; k < 60; k++) begin
            bit rdy;
            bit req;
            rdy = (k < 32) ? !rp[k] : 1'b1;
            req = ((k < 32) ? zp[k] : 1'b0) || rg;
            if (rdy && w16 && !io && k == 2 && req) return 2;
            if (rdy && k >= due) return k;
            if (rdy && req && !w16 && due == 6 && k == 3) due = 4;
            else if (rdy && req && !w16 && due == 6 && k == 4) due = 5;
        end
        return 0;
    endfunction

    task automatic run_cycle(input bit w16, input bit io, input bit rg,
                             input logic [31:0] zp, input logic [31:0] rp,
                             input string req, input bit poke_busy);
        int exp;
        int k;
        int oe_bad;
        bit fin;
        logic [CNT_W-1:0] len_seen;
        exp = exp_len(w16, io, rg, zp, rp);
        k = 0;
        oe_bad = 0;
        fin = 1'b0;
        @(negedge clk);
        start = 1'b1;
        wide16 = w16;
        io_cycle = io;
        reg_hit = rg;
        @(negedge clk);
        start = 1'b0;
        wide16 = !w16;   // R9: changes after acceptance must not matter
        io_cycle = !io;
        reg_hit = !rg;
        for (int g = 0; g < 100 && !fin; g++) begin
            if (done) begin
                fin = 1'b1;
            end else begin
                if (cmd_act) begin
                    k++;
                    if (nows_oe != (rg && k >= 2)) oe_bad++;
                    if (nows_oe && nows_out_n) oe_bad++;
                    nows_n = (k < 32) ? !zp[k] : 1'b1;
                    chrdy = (k < 32) ? !rp[k] : 1'b1;
                    start = poke_busy && (k == 2);
                end
                @(negedge clk);
            end
        end
        start = 1'b0;
        nows_n = 1'b1;
        chrdy = 1'b1;
        chk(fin, {req, " done seen"}, fin, 1);
        chk(int'(cyc_len) == exp, {req, " cyc_len"}, cyc_len, exp);
        chk(k == exp, {req, " R10 cmd_act clocks"}, k, exp);
        chk(!cmd_act, {req, " R7 cmd_act low with done"}, cmd_act, 0);
        chk(oe_bad == 0, {req, " R8 nows_oe window"}, oe_bad, 0);
        len_seen = cyc_len;
        @(negedge clk);
        chk(!done, {req, " R7 done one clock"}, done, 0);
        chk(!cmd_act, {req, " R9 no new cycle"}, cmd_act, 0);
        repeat (2) @(negedge clk);
        chk(cyc_len == len_seen, {req, " R7 cyc_len held"}, cyc_len, len_seen);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!cmd_act && !done && !nows_oe && nows_out_n && cyc_len == 0,
            "R1 reset state", {cmd_act, done, nows_oe, nows_out_n}, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(!cmd_act, "R1 idle after reset", cmd_act, 0);

        run_cycle(1, 0, 0, 32'h0, 32'h0, "R2 16b mem default", 0);
        run_cycle(1, 1, 0, 32'h0, 32'h0, "R2 16b io default", 0);
        run_cycle(1, 0, 0, 32'h4, 32'h0, "R3 16b mem fast", 0);
        run_cycle(1, 1, 0, 32'hFFFF_FFFC, 32'h0, "R4 16b io request", 0);
        run_cycle(0, 0, 0, 32'h0, 32'h0, "R5 8b default", 0);
        run_cycle(0, 1, 0, 32'h8, 32'h0, "R5 8b req bclk3", 0);
        run_cycle(0, 0, 0, 32'h10, 32'h0, "R5 8b req bclk4", 0);
        run_cycle(0, 0, 0, 32'h20, 32'h0, "R5 8b req bclk5", 0);
        run_cycle(0, 0, 0, 32'h4, 32'h0, "R5 8b req bclk2", 0);
        run_cycle(1, 0, 0, 32'h4, 32'h4, "R6 not-ready beats request", 0);
        run_cycle(0, 0, 0, 32'h8, 32'h8, "R6 8b not-ready bclk3", 0);
        run_cycle(0, 0, 0, 32'h0, 32'hC0, "R6 8b stretched", 0);
        run_cycle(1, 0, 1, 32'h0, 32'h0, "R8 reg access 16b mem", 0);
        run_cycle(0, 1, 1, 32'h0, 32'h0, "R8 reg access 8b", 0);
        run_cycle(1, 1, 0, 32'h0, 32'h0, "R9 start while busy", 1);

        for (int i = 0; i < 60; i++) begin
            bit w16;
            bit io;
            bit rg;
            logic [31:0] zp;
            logic [31:0] rp;
            w16 = 1'($urandom);
            io = 1'($urandom);
            rg = (($urandom % 8) == 0);
            zp = $urandom & $urandom;
            rp = ($urandom & $urandom & $urandom) & 32'h0000_0FFE;
            run_cycle(w16, io, rg, zp, rp, "R6 random", 1'($urandom));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule